// File: doc/BRIEF.md
# Power-of-Two Output Divider with Glitch-Free Enable

This block takes a fast oscillator clock and divides it by 2, 4, 8, 16 or 32, as chosen by a 3-bit ratio code. The divided clock leaves the block as a complementary pair, with a true output and an inverted output. The pair passes through an enable gate that is driven from an asynchronous enable input. The gate never emits a shortened high or low phase. When the gate is closed it parks the pair with the true output low and the complement high.

The enable input first passes through a synchronizer in the oscillator clock domain. The gate is a two-state machine with states `GATE_PARKED` and `GATE_RUNNING`. Its transition ARM (PARKED to RUNNING, synchronized enable high) and its transition PARK (RUNNING to PARKED, synchronized enable low) both fire only on the terminal count of the divider. The terminal count is the cycle that ends a high phase. A ratio code is held as pending and becomes the working ratio only at that same terminal count, so every output period belongs entirely to one ratio. The ratio code is treated as synchronous to the oscillator clock.

Top module: `pow2_outdiv`

## Requirements
- R1: While reset is asserted and after its release, `clk_out_p` is 0 and `clk_out_n` is 1 until the synchronized enable has been seen high. The working ratio after reset is 2.
- R2: Ratio code values 1, 2, 3, 4 and 5 select division by 2, 4, 8, 16 and 32. While enabled, the output is high for exactly half the ratio and low for exactly half the ratio, counted in oscillator cycles.
- R3: Ratio code values 0, 6 and 7 leave the working ratio unchanged.
- R4: A new ratio takes effect only at the terminal count of the current period. Every high phase on `clk_out_p` lasts exactly half of either the old ratio or the new ratio.
- R5: While the gate is parked, `clk_out_p` is 0 and `clk_out_n` is 1.
- R6: `clk_out_n` is always the complement of `clk_out_p`.
- R7: A change of `enable_async` acts only after it has passed a two-stage synchronizer, and only at the end of a high phase. A disable therefore lets the current high phase finish in full, and a one-cycle drop of the enable creates no runt pulse.
- R8: After an enable, the output stays low for at least half the ratio, and the first high phase lasts exactly half the ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast oscillator clock that is divided |
| rst_n | input | 1 | Active-low reset, synchronous to clk_vco |
| enable_async | input | 1 | Output enable, asynchronous to clk_vco |
| ratio_code | input | 3 | Division select: 1..5 give ratios 2..32, other values are ignored |
| clk_out_p | output | 1 | Divided clock, true polarity |
| clk_out_n | output | 1 | Divided clock, complement polarity |

## Verification
The bench builds the block with its default parameters: a maximum shift of 5 and two synchronizer stages. With these values every legal ratio from 2 to 32 can be reached, as can all three ignored codes 0, 6 and 7. The exact synchronizer delay is visible at ratio 2, where a gate that acted early would show at once. A ratio switch from 32 down to 2 in the middle of a high phase shows whether a long phase is cut short, and a one-cycle enable drop at ratio 8 shows whether the gate emits a partial pulse.

// File: rtl/pow2_outdiv_pkg.sv
package pow2_outdiv_pkg;

    // Output gate states
    typedef enum logic [0:0] {
        GATE_PARKED  = 1'b0,
        GATE_RUNNING = 1'b1
    } gate_state_e;

    // Ratio update states: idle or a ratio waiting for the terminal count
    typedef enum logic [0:0] {
        RATIO_STEADY  = 1'b0,
        RATIO_PENDING = 1'b1
    } ratio_state_e;

endpackage

// File: rtl/pow2_outdiv_sync.sv
module pow2_outdiv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pow2_outdiv_ratio.sv
module pow2_outdiv_ratio
    import pow2_outdiv_pkg::*;
#(
    parameter int MAX_SHIFT = 5,
    parameter int CODE_W    = 3,
    parameter int SH_W      = $clog2(MAX_SHIFT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ratio_code,
    output logic              term_cnt,
    output logic              phase_hi
);

    localparam int CNT_W = MAX_SHIFT;

    ratio_state_e     rstate_q, rstate_d;
    logic [SH_W-1:0]  shift_q,  shift_d;
    logic [SH_W-1:0]  pend_q,   pend_d;
    logic [CNT_W-1:0] cnt_q,    cnt_d;
    logic [CNT_W-1:0] cnt_mask;
    logic [CNT_W-1:0] top_bit;
    logic             code_ok;

    assign code_ok = (int'(ratio_code) >= 1) && (int'(ratio_code) <= MAX_SHIFT);

    // Mask of the active counter bits and the bit that marks the high half
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            cnt_mask[i] = (i < int'(shift_q));
            top_bit[i]  = (i == int'(shift_q) - 1);
        end
    end

    assign term_cnt = (cnt_q == cnt_mask);
    assign phase_hi = |(cnt_q & top_bit);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rstate_q <= RATIO_STEADY;
            shift_q  <= SH_W'(1);
            pend_q   <= SH_W'(1);
            cnt_q    <= '0;
        end else begin
            rstate_q <= rstate_d;
            shift_q  <= shift_d;
            pend_q   <= pend_d;
            cnt_q    <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        rstate_d = rstate_q;
        shift_d  = shift_q;
        pend_d   = pend_q;
        cnt_d    = term_cnt ? '0 : cnt_q + 1'b1;
        unique case (rstate_q)
            RATIO_STEADY: begin
                if (code_ok && (SH_W'(ratio_code) != shift_q)) begin
                    pend_d   = SH_W'(ratio_code);
                    rstate_d = RATIO_PENDING;
                end
            end
            RATIO_PENDING: begin
                if (term_cnt) begin
                    shift_d  = pend_q;
                    rstate_d = RATIO_STEADY;
                end
                if (code_ok) pend_d = SH_W'(ratio_code);
            end
        endcase
    end

    // R2
    shift_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(shift_q) >= 1) && (int'(shift_q) <= MAX_SHIFT));

    // R4
    ratio_at_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_q != $past(shift_q)) |-> $past(term_cnt));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q & ~cnt_mask) == '0);

endmodule

// File: rtl/pow2_outdiv_gate.sv
module pow2_outdiv_gate
    import pow2_outdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_sync,
    input  logic term_cnt,
    input  logic phase_hi,
    output logic out_p,
    output logic out_n
);

    gate_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_PARKED;
        else        state_q <= state_d;
    end

    // Transitions ARM and PARK, only at the terminal count
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_PARKED:  if (term_cnt && en_sync)  state_d = GATE_RUNNING;
            GATE_RUNNING: if (term_cnt && !en_sync) state_d = GATE_PARKED;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_p <= 1'b0;
            out_n <= 1'b1;
        end else begin
            unique case (state_q)
                GATE_PARKED: begin
                    out_p <= 1'b0;
                    out_n <= 1'b1;
                end
                GATE_RUNNING: begin
                    out_p <= phase_hi;
                    out_n <= !phase_hi;
                end
            endcase
        end
    end

    // R7
    gate_at_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> $past(term_cnt));

    // R6
    pair_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_n == !out_p);

    // R5
    parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_PARKED) |=> !out_p);

    // R8
    arm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == GATE_PARKED && state_q == GATE_RUNNING) |=> !out_p);

endmodule

// File: rtl/pow2_outdiv.sv
module pow2_outdiv #(
    parameter int MAX_SHIFT   = 5,
    parameter int CODE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_vco,
    input  logic              rst_n,
    input  logic              enable_async,
    input  logic [CODE_W-1:0] ratio_code,
    output logic              clk_out_p,
    output logic              clk_out_n
);

    localparam int SH_W = $clog2(MAX_SHIFT + 1);

    logic en_sync;
    logic term_cnt;
    logic phase_hi;

    pow2_outdiv_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk_vco),
        .rst_n   (rst_n),
        .d_async (enable_async),
        .q_sync  (en_sync)
    );

    pow2_outdiv_ratio #(
        .MAX_SHIFT (MAX_SHIFT),
        .CODE_W    (CODE_W),
        .SH_W      (SH_W)
    ) u_ratio (
        .clk        (clk_vco),
        .rst_n      (rst_n),
        .ratio_code (ratio_code),
        .term_cnt   (term_cnt),
        .phase_hi   (phase_hi)
    );

    pow2_outdiv_gate u_gate (
        .clk      (clk_vco),
        .rst_n    (rst_n),
        .en_sync  (en_sync),
        .term_cnt (term_cnt),
        .phase_hi (phase_hi),
        .out_p    (clk_out_p),
        .out_n    (clk_out_n)
    );

endmodule

// File: tb/test_pow2_outdiv.sv
`timescale 1ns/1ps
module test_pow2_outdiv;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [2:0] code = 3'd1;
    logic       out_p, out_n;

    int checks = 0;
    int fails  = 0;
    int exp_half  = 1;
    int prev_half = 1;
    int hi_len = 0;
    logic last_p = 1'b0;
    bit mon_on = 1'b0;

    always #2.5 clk = ~clk;

    pow2_outdiv i_pow2_outdiv (
        .clk_vco      (clk),
        .rst_n        (rst_n),
        .enable_async (en),
        .ratio_code   (code),
        .clk_out_p    (out_p),
        .clk_out_n    (out_n)
    );

    // Each entry: {ratio code, expected half period}
    localparam logic [7:0] VEC [8] = '{
        {3'd1, 5'd1}, {3'd3, 5'd4}, {3'd5, 5'd16}, {3'd0, 5'd16},
        {3'd2, 5'd2}, {3'd7, 5'd2}, {3'd4, 5'd8},  {3'd6, 5'd8}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Measure one full high phase and the following low phase
    task automatic measure(output int hi, output int lo);
        hi = 0;
        lo = 0;
        do @(negedge clk); while (out_p !== 1'b0);
        do @(negedge clk); while (out_p !== 1'b1);
        while (out_p === 1'b1) begin hi++; @(negedge clk); end
        while (out_p === 1'b0) begin lo++; @(negedge clk); end
    endtask

    // Run monitor: R6 on every sample, R4 on every completed high phase
    always @(negedge clk) begin
        if (mon_on) begin
            check(out_n === !out_p, "R6 complement", int'(out_n), int'(!out_p));
            if (out_p === 1'b1) hi_len++;
            else if (last_p === 1'b1) begin
                check(hi_len == exp_half || hi_len == prev_half,
                      "R4 high phase length", hi_len, exp_half);
                hi_len = 0;
            end
            last_p = out_p;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int hi, lo, seen_hi;
        // Reset state
        repeat (4) @(negedge clk);
        check(out_p === 1'b0 && out_n === 1'b1, "R1 reset pair", int'(out_p), 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        check(out_p === 1'b0 && out_n === 1'b1, "R1 parked without enable", int'(out_p), 0);
        mon_on = 1'b1;
        en = 1'b1;

        // Table walk over legal and ignored codes
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            code = VEC[i][7:5];
            prev_half = exp_half;
            exp_half = int'(VEC[i][4:0]);
            repeat (120) @(negedge clk);
            prev_half = exp_half;
            measure(hi, lo);
            if (code >= 3'd1 && code <= 3'd5) begin
                check(hi == exp_half, "R2 high length", hi, exp_half);
                check(lo == exp_half, "R2 low length", lo, exp_half);
            end else begin
                check(hi == exp_half, "R3 high length kept", hi, exp_half);
                check(lo == exp_half, "R3 low length kept", lo, exp_half);
            end
        end

        // R7: disable at ratio 2 must wait for synchronizer
        code = 3'd1; prev_half = exp_half; exp_half = 1;
        repeat (60) @(negedge clk);
        prev_half = 1;
        en = 1'b0;
        seen_hi = 0;
        repeat (2) begin
            @(negedge clk);
            if (out_p === 1'b1) seen_hi++;
        end
        check(seen_hi >= 1, "R7 disable delayed by sync", seen_hi, 1);
        repeat (60) @(negedge clk);
        check(out_p === 1'b0 && out_n === 1'b1, "R5 parked pair", int'(out_p), 0);

        // R8: enable at ratio 8
        code = 3'd3;
        repeat (40) @(negedge clk);
        exp_half = 4; prev_half = 4;
        en = 1'b1;
        lo = 0;
        @(negedge clk);
        while (out_p === 1'b0) begin lo++; @(negedge clk); end
        check(lo >= 4, "R8 leading low phase", lo, 4);
        hi = 0;
        while (out_p === 1'b1) begin hi++; @(negedge clk); end
        check(hi == 4, "R8 first high phase", hi, 4);

        // R7: one-cycle enable drop must not shorten any phase
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        repeat (60) @(negedge clk);
        measure(hi, lo);
        check(hi == 4 && lo == 4, "R7 after enable glitch", hi, 4);

        // R4: ratio change 32 -> 2 during a high phase
        code = 3'd5; exp_half = 16; prev_half = 4;
        repeat (200) @(negedge clk);
        prev_half = 16;
        do @(negedge clk); while (out_p !== 1'b0);
        do @(negedge clk); while (out_p !== 1'b1);
        code = 3'd1; exp_half = 1;
        hi = 0;
        while (out_p === 1'b1) begin hi++; @(negedge clk); end
        check(hi == 16, "R4 old phase completes", hi, 16);
        measure(hi, lo);
        check(hi == 1 && lo == 1, "R4 new ratio applied", hi, 1);

        repeat (10) @(negedge clk);
        summary();
        $finish;
    end

endmodule